// File: doc/BRIEF.md
# Configuration Frame Receive Parser

This block sits behind a receive byte interface and interprets configuration frames sent by a host to a hardware traffic generator. Every byte arrives with a valid strobe and start-of-frame and end-of-frame flags. The byte flagged as start of frame is an operation code. The bytes after it are payload straight away, because these frames carry no addressing header.

The operation code selects where the payload goes. It can load a replay-count register. It can write 16-byte entries into an external preconfigured lookup table through a write port. Or it can be unpacked as a stream of variable-length configuration sets. Each set opens with a control byte whose low six bits say which header fields follow. The parser collects each complete set and turns it into one fixed-width record for an operation FIFO, with zeros in every field slot the set did not carry. The FIFO storage itself is outside the block, and so are the MAC, the FCS check and frame generation.

Nothing is ever pushed back toward the sender. A set that completes while the FIFO reports full is discarded. A set cut short by the end of its frame, or by a new start of frame, is discarded as well.

Top module: `cfg_rx_parser`

## Requirements
- R1: After reset, `rec_valid` and `tbl_we` are low and `replay_count` is zero.
- R2: The byte presented with `in_sof` high is the operation code. 0x01 selects replay load, 0x02 selects table write and 0x03 selects configuration sets. Any other code makes the rest of that frame change no output.
- R3: A set is its control byte followed by the fields whose control bits are set, taken in bit order. Bit0 is frame length (2 bytes), bit1 is IPv4 source (4), bit2 is IPv6 address (16), bit3 is the first VLAN tag (2), bit4 is the second VLAN tag (2) and bit5 is the table index (2). Every field is sent most significant byte first. Bits 6 and 7 add no bytes.
- R4: A completed set appears as `rec_data` with `rec_valid` high for one cycle, on the cycle after its last byte. The layout is ctrl[231:224], length[223:208], IPv4[207:176], IPv6[175:48], VLAN A[47:32], VLAN B[31:16] and index[15:0]. Absent fields read zero. Sets packed back to back in one frame each give one record, in order.
- R5: A set left unfinished when its frame ends, or when a new `in_sof` byte arrives, produces no record. Sets already completed in that frame are kept.
- R6: If `fifo_full` is high in the cycle a set's last byte is presented, that set is dropped. Later sets are unaffected.
- R7: In a replay frame, the first two payload bytes (MSB first) load `replay_count`. A frame with fewer payload bytes leaves it unchanged, and further bytes are ignored.
- R8: In a table frame, the first two payload bytes give the start index, MSB first, of which the low `TBL_AW` bits are used. Each following 16 bytes produce one `tbl_we` pulse on the cycle after the 16th byte. The first byte of the entry lands in the top of `tbl_wdata`. Entries go to consecutive addresses, wrapping at the table size, and a trailing partial entry is not written.
- R9: Bytes with `in_valid` low are not consumed, and bytes after an end of frame and before the next `in_sof` change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | Byte is first of a frame |
| in_eof | input | 1 | Byte is last of a frame |
| in_data | input | 8 | Received byte |
| fifo_full | input | 1 | Operation FIFO cannot accept a record |
| rec_valid | output | 1 | Record write strobe |
| rec_data | output | 232 | Packed configuration record |
| tbl_we | output | 1 | Lookup-table write strobe |
| tbl_addr | output | TBL_AW | Lookup-table write address |
| tbl_wdata | output | 8*ENTRY_BYTES | Lookup-table entry |
| replay_count | output | REPLAY_W | Replay-count register |

## Verification
Two events can fall in the same cycle. A set can complete on the very byte that carries the end-of-frame flag, and a set can complete while `fifo_full` is high. The bench sweeps all 64 combinations of field bits in a single frame, so the final set ends exactly on the frame's last byte, and that record must still appear. It also raises `fifo_full` across only the middle one of three sets, and then expects exactly the first and third records. Table index wrap, truncated sets, restarts without an end of frame and unknown codes are judged from the outputs against values computed from the requirement layouts.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  localparam int NFIELD   = 6;
  localparam int MAX_DATA = 28;
  localparam int REC_W    = 8 + 8 * MAX_DATA;

  // byte count and slot position (byte 0 = most significant) of each field
  localparam logic [5:0] FIELD_BYTES [NFIELD] = '{6'd2, 6'd4, 6'd16, 6'd2, 6'd2, 6'd2};
  localparam logic [5:0] FIELD_BASE  [NFIELD] = '{6'd0, 6'd2, 6'd6, 6'd22, 6'd24, 6'd26};

  typedef struct packed {
    logic [7:0]   ctrl;
    logic [15:0]  flen;
    logic [31:0]  ipv4;
    logic [127:0] ipv6;
    logic [15:0]  vlan_a;
    logic [15:0]  vlan_b;
    logic [15:0]  tidx;
  } cfg_rec_t;

  typedef enum logic [2:0] {M_IDLE, M_REPLAY, M_TABLE, M_SETS, M_SKIP} rx_mode_e;

  function automatic logic [5:0] set_data_len(input logic [7:0] c);
    logic [5:0] n;
    n = '0;
    for (int i = 0; i < NFIELD; i++)
      if (c[i]) n = n + FIELD_BYTES[i];
    return n;
  endfunction
endpackage

// File: rtl/cfg_set_packer.sv
module cfg_set_packer
  import cfg_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     byte_en,
  input  logic [7:0] byte_data,
  input  logic     frame_last,
  input  logic     restart,
  input  logic     fifo_full,
  output logic     rec_valid,
  output cfg_rec_t rec_q
);
  logic       in_set;
  logic [7:0] ctrl_q;
  logic [5:0] need_q;
  logic [5:0] idx_q;
  logic [7:0] buf_q [MAX_DATA];

  logic [5:0] new_len;
  logic [7:0] ctrl_cur;
  logic       done;
  logic [7:0] cur  [MAX_DATA];
  logic [7:0] slot [MAX_DATA];
  logic [8*MAX_DATA-1:0] body;
  int off;
  int p;
  int q;

  assign new_len  = set_data_len(byte_data);
  assign ctrl_cur = in_set ? ctrl_q : byte_data;
  assign done     = byte_en && (in_set ? (idx_q == need_q - 6'd1) : (new_len == 6'd0));

  always_comb begin
    for (int k = 0; k < MAX_DATA; k++)
      cur[k] = (in_set && byte_en && idx_q == 6'(k)) ? byte_data : buf_q[k];
    for (int k = 0; k < MAX_DATA; k++) slot[k] = '0;
    off = 0;
    p = 0;
    q = 0;
    for (int i = 0; i < NFIELD; i++) begin
      if (ctrl_cur[i]) begin
        for (int b = 0; b < 16; b++) begin
          p = int'(FIELD_BASE[i]) + b;
          q = off + b;
          if (b < int'(FIELD_BYTES[i]) && p < MAX_DATA && q < MAX_DATA)
            slot[p] = cur[q];
        end
        off = off + int'(FIELD_BYTES[i]);
      end
    end
    for (int k = 0; k < MAX_DATA; k++)
      body[8*(MAX_DATA-k)-1 -: 8] = slot[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_set    <= 1'b0;
      ctrl_q    <= '0;
      need_q    <= '0;
      idx_q     <= '0;
      rec_valid <= 1'b0;
      rec_q     <= '0;
    end else begin
      rec_valid <= done && !fifo_full;
      if (done && !fifo_full) rec_q <= {ctrl_cur, body};
      if (restart) begin
        in_set <= 1'b0;
      end else if (byte_en) begin
        if (!in_set) begin
          ctrl_q <= byte_data;
          need_q <= new_len;
          idx_q  <= '0;
          in_set <= (new_len != 6'd0) && !frame_last;
        end else begin
          idx_q <= idx_q + 6'd1;
          if (done || frame_last) in_set <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (byte_en && in_set && idx_q < 6'(MAX_DATA)) buf_q[idx_q[4:0]] <= byte_data;
  end

  // R3: an open set always has bytes left to collect
  a_r3_open_set_pending: assert property (@(posedge clk) disable iff (rst)
    in_set |-> (need_q != 6'd0 && idx_q < need_q));
  // R4: a field the control byte omits is delivered as zeros
  a_r4_absent_zero: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_q.ctrl[2]) |-> (rec_q.ipv6 == '0));
endmodule

// File: rtl/cfg_tbl_writer.sv
module cfg_tbl_writer #(
  parameter int TBL_AW      = 8,
  parameter int ENTRY_BYTES = 16,
  localparam int DW         = 8 * ENTRY_BYTES,
  localparam int CW         = $clog2(ENTRY_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_en,
  input  logic [7:0]    byte_data,
  input  logic          frame_last,
  input  logic          restart,
  output logic          tbl_we,
  output logic [TBL_AW-1:0] tbl_addr,
  output logic [DW-1:0] tbl_wdata
);
  logic [1:0]        hdr_q;
  logic [7:0]        hi_q;
  logic [TBL_AW-1:0] ptr_q;
  logic [CW-1:0]     cnt_q;
  logic [DW-9:0]     sr_q;
  logic [15:0]       start_idx;
  logic              entry_done;

  assign start_idx  = {hi_q, byte_data};
  assign entry_done = byte_en && hdr_q == 2'd2 && cnt_q == CW'(ENTRY_BYTES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q     <= '0;
      hi_q      <= '0;
      ptr_q     <= '0;
      cnt_q     <= '0;
      sr_q      <= '0;
      tbl_we    <= 1'b0;
      tbl_addr  <= '0;
      tbl_wdata <= '0;
    end else begin
      tbl_we <= entry_done;
      if (entry_done) begin
        tbl_addr  <= ptr_q;
        tbl_wdata <= {sr_q, byte_data};
      end
      if (restart) begin
        hdr_q <= '0;
        cnt_q <= '0;
      end else if (byte_en) begin
        if (hdr_q == 2'd0) begin
          hi_q  <= byte_data;
          hdr_q <= 2'd1;
        end else if (hdr_q == 2'd1) begin
          ptr_q <= start_idx[TBL_AW-1:0];
          hdr_q <= 2'd2;
        end else begin
          sr_q <= {sr_q[DW-17:0], byte_data};
          if (entry_done) begin
            cnt_q <= '0;
            ptr_q <= ptr_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        if (frame_last) begin
          hdr_q <= '0;
          cnt_q <= '0;
        end
      end
    end
  end

  // R8: entries need many bytes each, so write strobes never come back to back
  a_r8_we_spaced: assert property (@(posedge clk) disable iff (rst)
    tbl_we |=> !tbl_we);
endmodule

// File: rtl/cfg_rx_parser.sv
module cfg_rx_parser
  import cfg_rx_pkg::*;
#(
  parameter int TBL_AW      = 8,
  parameter int ENTRY_BYTES = 16,
  parameter int REPLAY_W    = 16,
  parameter logic [7:0] OP_REPLAY = 8'h01,
  parameter logic [7:0] OP_TABLE  = 8'h02,
  parameter logic [7:0] OP_SETS   = 8'h03
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_sof,
  input  logic                     in_eof,
  input  logic [7:0]               in_data,
  input  logic                     fifo_full,
  output logic                     rec_valid,
  output logic [REC_W-1:0]         rec_data,
  output logic                     tbl_we,
  output logic [TBL_AW-1:0]        tbl_addr,
  output logic [8*ENTRY_BYTES-1:0] tbl_wdata,
  output logic [REPLAY_W-1:0]      replay_count
);
  rx_mode_e   mode_q;
  logic       sof_byte;
  logic       pay_byte;
  logic [7:0] rp_hi_q;
  logic [1:0] rp_cnt_q;
  cfg_rec_t   rec;

  assign sof_byte = in_valid && in_sof;
  assign pay_byte = in_valid && !in_sof;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= M_IDLE;
      rp_hi_q      <= '0;
      rp_cnt_q     <= '0;
      replay_count <= '0;
    end else begin
      if (sof_byte) begin
        rp_cnt_q <= '0;
        if (in_eof)                  mode_q <= M_IDLE;
        else if (in_data == OP_REPLAY) mode_q <= M_REPLAY;
        else if (in_data == OP_TABLE)  mode_q <= M_TABLE;
        else if (in_data == OP_SETS)   mode_q <= M_SETS;
        else                           mode_q <= M_SKIP;
      end else if (pay_byte) begin
        if (mode_q == M_REPLAY) begin
          if (rp_cnt_q == 2'd0) begin
            rp_hi_q  <= in_data;
            rp_cnt_q <= 2'd1;
          end else if (rp_cnt_q == 2'd1) begin
            replay_count <= REPLAY_W'({rp_hi_q, in_data});
            rp_cnt_q     <= 2'd2;
          end
        end
        if (in_eof) mode_q <= M_IDLE;
      end
    end
  end

  cfg_set_packer u_pack (
    .clk        (clk),
    .rst        (rst),
    .byte_en    (pay_byte && mode_q == M_SETS),
    .byte_data  (in_data),
    .frame_last (in_eof),
    .restart    (sof_byte),
    .fifo_full  (fifo_full),
    .rec_valid  (rec_valid),
    .rec_q      (rec)
  );
  assign rec_data = rec;

  cfg_tbl_writer #(.TBL_AW(TBL_AW), .ENTRY_BYTES(ENTRY_BYTES)) u_tbl (
    .clk        (clk),
    .rst        (rst),
    .byte_en    (pay_byte && mode_q == M_TABLE),
    .byte_data  (in_data),
    .frame_last (in_eof),
    .restart    (sof_byte),
    .tbl_we     (tbl_we),
    .tbl_addr   (tbl_addr),
    .tbl_wdata  (tbl_wdata)
  );

  // R7: the replay register only moves on a payload byte of a replay frame
  a_r7_replay_source: assert property (@(posedge clk) disable iff (rst)
    !$stable(replay_count) |-> $past(pay_byte && mode_q == M_REPLAY));
  // R6: no record is issued for a set that completed while the FIFO was full
  a_r6_full_drops: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> !$past(fifo_full));
  // R2: one frame type never produces both kinds of write at once
  a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
    !(rec_valid && tbl_we));
  // R9: a record always follows a byte consumed in set mode
  a_r9_rec_needs_byte: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> $past(in_valid && mode_q == M_SETS));
endmodule

// File: tb/cfg_rx_parser_tb.sv
module cfg_rx_parser_tb;
  localparam int AW = 8;
  localparam int EB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, fifo_full = 1'b0;
  logic [7:0] in_data = '0;
  logic rec_valid, tbl_we;
  logic [231:0] rec_data;
  logic [AW-1:0] tbl_addr;
  logic [8*EB-1:0] tbl_wdata;
  logic [15:0] replay_count;

  always #4 clk = ~clk;

  cfg_rx_parser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .fifo_full(fifo_full), .rec_valid(rec_valid), .rec_data(rec_data),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .replay_count(replay_count)
  );

  int checks = 0;
  int failures = 0;

  int fsize [6] = '{2, 4, 16, 2, 2, 2};
  int fbase [6] = '{0, 2, 6, 22, 24, 26};

  logic [7:0] frm [0:2047];
  int frm_n;
  logic [231:0] exp_rec [0:127];
  int exp_n;
  logic [231:0] got_rec [0:127];
  int got_n = 0;
  logic [AW-1:0] got_addr [0:15];
  logic [8*EB-1:0] got_wd [0:15];
  int got_t = 0;
  int full_from = -1, full_to = -1;

  always @(negedge clk) begin
    if (!rst && rec_valid && got_n < 128) begin got_rec[got_n] = rec_data; got_n++; end
    if (!rst && tbl_we && got_t < 16) begin got_addr[got_t] = tbl_addr; got_wd[got_t] = tbl_wdata; got_t++; end
  end

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send_frame(input bit gaps);
    for (int i = 0; i < frm_n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = frm[i];
      in_sof = (i == 0); in_eof = (i == frm_n - 1);
      fifo_full = (i >= full_from && i <= full_to);
      if (gaps && (i % 3 == 2)) begin
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; fifo_full = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  // append one set with field values derived from seed; record the expected record
  task automatic add_set(input logic [7:0] c, input int seed, input bit expect_it);
    logic [7:0] slot [28];
    logic [231:0] r;
    int k;
    for (int j = 0; j < 28; j++) slot[j] = 8'h00;
    frm[frm_n] = c; frm_n++;
    k = 0;
    for (int i = 0; i < 6; i++)
      if (c[i])
        for (int b = 0; b < fsize[i]; b++) begin
          frm[frm_n] = 8'((seed * 37 + k * 11 + 5) & 255);
          slot[fbase[i] + b] = frm[frm_n];
          frm_n++; k++;
        end
    r = '0;
    r[231:224] = c;
    for (int j = 0; j < 28; j++) r[223 - 8*j -: 8] = slot[j];
    if (expect_it) begin exp_rec[exp_n] = r; exp_n++; end
  endtask

  task automatic compare_recs(input string req, input int base);
    check(got_n - base == exp_n, req, 256'(got_n - base), 256'(exp_n));
    for (int i = 0; i < exp_n && base + i < got_n; i++)
      check(got_rec[base + i] == exp_rec[i], req, 256'(got_rec[base + i]), 256'(exp_rec[i]));
  endtask

  int base;
  int tbase;
  logic [15:0] rp_before;

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rec_valid == 1'b0 && tbl_we == 1'b0, "R1", 256'({rec_valid, tbl_we}), 256'(0));
    check(replay_count == 16'h0, "R1", 256'(replay_count), 256'(0));

    // R3 R4: all 64 field combinations plus reserved-bit-only set, back to back; last ends on eof
    frm_n = 0; exp_n = 0; base = got_n;
    frm[0] = 8'h03; frm_n = 1;
    add_set(8'hC0, 99, 1);
    for (int c = 0; c < 64; c++) add_set(8'(c), c, 1);
    send_frame(1'b1);
    compare_recs("R3/R4 sweep", base);

    // R5: complete set kept, truncated IPv6 set dropped at eof
    frm_n = 0; exp_n = 0; base = got_n;
    frm[0] = 8'h03; frm_n = 1;
    add_set(8'h02, 7, 1);
    add_set(8'h04, 8, 0);
    frm_n = frm_n - 11;
    send_frame(1'b0);
    compare_recs("R5 eof truncation", base);

    // R5: new sof during an open set discards it (no eof sent for first frame)
    base = got_n;
    frm_n = 0; exp_n = 0;
    frm[0] = 8'h03; frm_n = 1;
    add_set(8'h01, 3, 0);
    for (int i = 0; i < frm_n - 1; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_sof = (i == 0); in_eof = 1'b0; in_data = frm[i];
    end
    frm_n = 0; exp_n = 0;
    frm[0] = 8'h03; frm_n = 1;
    add_set(8'h08, 4, 1);
    send_frame(1'b0);
    compare_recs("R5 restart", base);

    // R6: FIFO full during the last byte of the middle set only
    frm_n = 0; exp_n = 0; base = got_n;
    frm[0] = 8'h03; frm_n = 1;
    add_set(8'h01, 20, 1);
    full_from = frm_n;
    add_set(8'h01, 21, 0);
    full_to = frm_n - 1;
    add_set(8'h21, 22, 1);
    send_frame(1'b0);
    full_from = -1; full_to = -1;
    compare_recs("R6 drop on full", base);

    // R7: replay load, extra byte ignored
    frm_n = 4; frm[0] = 8'h01; frm[1] = 8'h12; frm[2] = 8'h34; frm[3] = 8'h56;
    send_frame(1'b1);
    check(replay_count == 16'h1234, "R7 load", 256'(replay_count), 256'(16'h1234));
    // R7: short replay frame leaves the register unchanged
    frm_n = 2; frm[0] = 8'h01; frm[1] = 8'hAB;
    send_frame(1'b0);
    check(replay_count == 16'h1234, "R7 short", 256'(replay_count), 256'(16'h1234));

    // R8: start index 0x01FE, three entries wrap past the top, partial entry dropped
    tbase = got_t; base = got_n;
    frm_n = 3; frm[0] = 8'h02; frm[1] = 8'h01; frm[2] = 8'hFE;
    for (int e = 0; e < 3; e++)
      for (int j = 0; j < EB; j++) begin frm[frm_n] = 8'(e * 16 + j + 1); frm_n++; end
    for (int j = 0; j < 5; j++) begin frm[frm_n] = 8'h03; frm_n++; end
    send_frame(1'b1);
    check(got_t - tbase == 3, "R8 count", 256'(got_t - tbase), 256'(3));
    for (int e = 0; e < 3 && tbase + e < got_t; e++) begin
      logic [127:0] w;
      for (int j = 0; j < EB; j++) w[127 - 8*j -: 8] = 8'(e * 16 + j + 1);
      check(got_addr[tbase + e] == 8'(254 + e), "R8 addr", 256'(got_addr[tbase + e]), 256'(8'(254 + e)));
      check(got_wd[tbase + e] == w, "R8 data", 256'(got_wd[tbase + e]), 256'(w));
    end
    check(got_n == base, "R8 no records", 256'(got_n), 256'(base));

    // R2: unknown opcode with set-like and replay-like payload changes nothing
    tbase = got_t; base = got_n; rp_before = replay_count;
    frm_n = 6; frm[0] = 8'h7F; frm[1] = 8'h00; frm[2] = 8'h00; frm[3] = 8'h01; frm[4] = 8'h99; frm[5] = 8'h00;
    send_frame(1'b0);
    check(got_n == base && got_t == tbase, "R2 unknown op", 256'({got_n, got_t}), 256'({base, tbase}));
    check(replay_count == rp_before, "R2 unknown op replay", 256'(replay_count), 256'(rp_before));

    // R9: bytes outside any frame are ignored
    base = got_n;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1; in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
    end
    @(posedge clk); #1; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(got_n == base && replay_count == 16'h1234, "R9 outside frame", 256'(got_n), 256'(base));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule